// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupts

This block is a bank of general-purpose I/O pins. A simple memory-mapped register port (address, write strobe, write data, combinational read data) configures it. Every pin has an output value bit and an output-enable bit. The sampled level of every pad can be read back.

Any pin can also act as an interrupt source. Each pin selects its own trigger type (level or edge) and its own polarity. Edge events are captured and held until software clears them with a write-one-to-clear acknowledge register. Level events simply follow the qualified pin level. An enable register qualifies the raw status and a mask register gates the masked status. A single interrupt line is raised while any masked status bit is set.

Pad inputs pass through a two-stage synchronizer before they reach the readback register and the interrupt logic. A filter-setting register exists only as read/write storage.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every stored register reads 0, `pinOe` and `pinOut` are 0 and `irqOut` is low.
- R2: Registers are read and written at these byte offsets: output value 0x00, output enable 0x04, irq enable 0x30, irq mask 0x34, trigger type 0x38, polarity 0x3C, filter storage 0x48. Reads of the acknowledge offset 0x4C and of unmapped offsets return 0.
- R3: `pinOut` equals the output value register and `pinOe` equals the output enable register (bit 1 = drive the pin) from the cycle after the write.
- R4: Offset 0x50 returns `pinIn` as it was two rising clock edges earlier.
- R5: With trigger type bit 0 (level), the raw status bit (offset 0x44) equals the synchronized pin level when the polarity bit is 1, and its inverse when the polarity bit is 0. Acknowledge writes leave it unchanged.
- R6: With trigger type bit 1 (edge), the raw status bit sets one clock after the synchronized level shows the selected edge (polarity 1 = rising, 0 = falling). It then holds after the pin returns.
- R7: Writing 1 to a bit at offset 0x4C clears that pin's captured edge. Bits written as 0 leave their pins unchanged.
- R8: An edge that is captured in the same cycle as an acknowledge write for that pin leaves the raw status bit set.
- R9: A pin whose enable bit is 0 shows raw status 0 and captures no edges.
- R10: The masked status (offset 0x40) equals raw status with mask-1 bits forced to 0. `irqOut` is high exactly when the masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Read data for `busAddr`, combinational |
| pinIn | input | NUM_PINS | Asynchronous pad levels |
| pinOut | output | NUM_PINS | Pad output values |
| pinOe | output | NUM_PINS | Pad output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
Register storage is exercised with mixed patterns such as A5A50F0F and FFFF0000. These catch swapped offsets, a dropped half-word or a field aliased to a neighbour.

The interrupt logic is driven with pins in each of the four trigger configurations side by side. A rising pin in falling-edge mode must stay quiet while its rising-edge neighbour fires, which separates polarity from type. Acknowledge writes are applied to level pins, to edge pins with zero and non-zero data, and in the exact cycle an edge is captured, which separates clear priority from set priority. Toggling a disabled pin and then re-enabling it shows whether edges leak into the capture while disabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // byte offsets seen by software
  localparam logic [7:0] OFF_DOUT = 8'h00;
  localparam logic [7:0] OFF_DIR  = 8'h04;
  localparam logic [7:0] OFF_EN   = 8'h30;
  localparam logic [7:0] OFF_MASK = 8'h34;
  localparam logic [7:0] OFF_TYPE = 8'h38;
  localparam logic [7:0] OFF_POL  = 8'h3C;
  localparam logic [7:0] OFF_MSTS = 8'h40;
  localparam logic [7:0] OFF_RSTS = 8'h44;
  localparam logic [7:0] OFF_FILT = 8'h48;
  localparam logic [7:0] OFF_ACK  = 8'h4C;
  localparam logic [7:0] OFF_PINS = 8'h50;

  typedef struct packed {
    logic wrDout;
    logic wrDir;
    logic wrEn;
    logic wrMask;
    logic wrType;
    logic wrPol;
    logic wrFilt;
    logic wrAck;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_DOUT, RD_DIR, RD_EN, RD_MASK, RD_TYPE,
    RD_POL, RD_MSTS, RD_RSTS, RD_FILT, RD_PINS
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         strobe,
  output rdSel_t            rdSel
);

  localparam int OFF_W = 8;
  logic [OFF_W-1:0] offset;
  logic             inRange;

  generate
    if (ADDR_W > OFF_W) begin : g_wide
      assign offset  = busAddr[OFF_W-1:0];
      assign inRange = (busAddr[ADDR_W-1:OFF_W] == '0);
    end else begin : g_narrow
      assign offset  = OFF_W'(busAddr);
      assign inRange = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    if (inRange) begin
      case (offset)
        OFF_DOUT: begin strobe.wrDout = busWe; rdSel = RD_DOUT; end
        OFF_DIR:  begin strobe.wrDir  = busWe; rdSel = RD_DIR;  end
        OFF_EN:   begin strobe.wrEn   = busWe; rdSel = RD_EN;   end
        OFF_MASK: begin strobe.wrMask = busWe; rdSel = RD_MASK; end
        OFF_TYPE: begin strobe.wrType = busWe; rdSel = RD_TYPE; end
        OFF_POL:  begin strobe.wrPol  = busWe; rdSel = RD_POL;  end
        OFF_MSTS: rdSel = RD_MSTS;
        OFF_RSTS: rdSel = RD_RSTS;
        OFF_FILT: begin strobe.wrFilt = busWe; rdSel = RD_FILT; end
        OFF_ACK:  strobe.wrAck = busWe;
        OFF_PINS: rdSel = RD_PINS;
        default:  rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  rdSel_t              rdSel,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinLvl,
  output logic [NUM_PINS-1:0] edgeLatch,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] doutQ, dirQ, enQ, maskQ, typeQ, polQ, filtQ;
  logic [NUM_PINS-1:0] syncQ1, syncQ2, prevQ;
  logic [NUM_PINS-1:0] latchQ, latchNxt, ackClr, rawSts, mskSts;

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ <= '0; dirQ <= '0; enQ <= '0; maskQ <= '0;
      typeQ <= '0; polQ <= '0; filtQ <= '0;
    end else begin
      if (strobe.wrDout) doutQ <= wdata;
      if (strobe.wrDir)  dirQ  <= wdata;
      if (strobe.wrEn)   enQ   <= wdata;
      if (strobe.wrMask) maskQ <= wdata;
      if (strobe.wrType) typeQ <= wdata;
      if (strobe.wrPol)  polQ  <= wdata;
      if (strobe.wrFilt) filtQ <= wdata;
    end
  end

  // two-stage synchronizer plus previous-level history for edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= '0; syncQ2 <= '0; prevQ <= '0; latchQ <= '0;
    end else begin
      syncQ1 <= pinIn;
      syncQ2 <= syncQ1;
      prevQ  <= syncQ2;
      latchQ <= latchNxt;
    end
  end

  assign ackClr = strobe.wrAck ? wdata : '0;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseEv, fallEv, edgeHit, lvlAct, armed;
    assign riseEv  = syncQ2[i] & ~prevQ[i];
    assign fallEv  = ~syncQ2[i] & prevQ[i];
    assign armed   = enQ[i] & typeQ[i];
    assign edgeHit = armed & (polQ[i] ? riseEv : fallEv);
    assign lvlAct  = polQ[i] ? syncQ2[i] : ~syncQ2[i];
    // a fresh edge wins over a simultaneous acknowledge
    assign latchNxt[i] = edgeHit | (latchQ[i] & armed & ~ackClr[i]);
    assign rawSts[i]   = enQ[i] & (typeQ[i] ? latchQ[i] : lvlAct);
  end

  assign mskSts    = rawSts & ~maskQ;
  assign irqOut    = |mskSts;
  assign pinOut    = doutQ;
  assign pinOe     = dirQ;
  assign pinLvl    = syncQ2;
  assign edgeLatch = latchQ;

  always_comb begin
    case (rdSel)
      RD_DOUT: rdata = doutQ;
      RD_DIR:  rdata = dirQ;
      RD_EN:   rdata = enQ;
      RD_MASK: rdata = maskQ;
      RD_TYPE: rdata = typeQ;
      RD_POL:  rdata = polQ;
      RD_MSTS: rdata = mskSts;
      RD_RSTS: rdata = rawSts;
      RD_FILT: rdata = filtQ;
      RD_PINS: rdata = syncQ2;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);

  wrStrobe_t           strobe;
  rdSel_t              rdSel;
  logic [NUM_PINS-1:0] pinLvl;
  logic [NUM_PINS-1:0] edgeLatch;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .rdata     (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinLvl    (pinLvl),
    .edgeLatch (edgeLatch),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] busRdata,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] pinLvl,
  input logic [NUM_PINS-1:0] edgeLatch
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic wrAckOrCfg;
  assign wrAckOrCfg = busWe && (busAddr == ADDR_W'(8'h4C) ||
                                busAddr == ADDR_W'(8'h30) ||
                                busAddr == ADDR_W'(8'h38));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && pinOe == '0 && pinOut == '0));

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(8'h04)) |=> (pinOe == $past(busWdata)));

  // R3
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(8'h00)) |=> (pinOut == $past(busWdata)));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2) |-> (pinLvl == $past(pinIn, 2)));

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrAckOrCfg |=> ((edgeLatch & $past(edgeLatch)) == $past(edgeLatch)));

  // R10
  irq_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(8'h40)) |-> ((busRdata != '0) == irqOut));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .pinIn     (pinIn),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .irqOut    (irqOut),
  .pinLvl    (pinLvl),
  .edgeLatch (edgeLatch)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irqOut;

  int nVec = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // register storage walk (R2); pins held low, enable kept 0 except briefly
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'hA5A5_0F0F, 32'h0},
    '{1'b0, 8'h00, 32'h0, 32'hA5A5_0F0F},
    '{1'b1, 8'h04, 32'hFFFF_0000, 32'h0},
    '{1'b0, 8'h04, 32'h0, 32'hFFFF_0000},
    '{1'b1, 8'h34, 32'h1234_5678, 32'h0},
    '{1'b0, 8'h34, 32'h0, 32'h1234_5678},
    '{1'b1, 8'h38, 32'h0F0F_00F0, 32'h0},
    '{1'b0, 8'h38, 32'h0, 32'h0F0F_00F0},
    '{1'b1, 8'h3C, 32'hC3C3_3C3C, 32'h0},
    '{1'b0, 8'h3C, 32'h0, 32'hC3C3_3C3C},
    '{1'b1, 8'h48, 32'h0000_FFFF, 32'h0},
    '{1'b0, 8'h48, 32'h0, 32'h0000_FFFF},
    '{1'b1, 8'h30, 32'h8000_0001, 32'h0},
    '{1'b0, 8'h30, 32'h0, 32'h8000_0001},
    '{1'b1, 8'h30, 32'h0, 32'h0},
    '{1'b0, 8'h4C, 32'h0, 32'h0},
    '{1'b0, 8'h60, 32'h0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdNow(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a; busWe = 1'b0;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdNow(tag, a, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    rdNow("R1 dout", 8'h00, 32'h0);
    rdNow("R1 en", 8'h30, 32'h0);
    rdNow("R1 raw", 8'h44, 32'h0);
    chk("R1 oe", pinOe, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2 table walk
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].isWr) wr(VECS[k].addr, VECS[k].data);
      else rd("R2 table", VECS[k].addr, VECS[k].exp);
    end
    wr(8'h38, 32'h0); wr(8'h3C, 32'h0); wr(8'h34, 32'h0);

    // R3 pad drive
    chk("R3 pinOut", pinOut, 32'hA5A5_0F0F);
    chk("R3 pinOe", pinOe, 32'hFFFF_0000);

    // R4 two-edge synchronizer latency
    @(negedge clk); pinIn = 32'hDEAD_BEEF;
    @(negedge clk); rdNow("R4 one edge", 8'h50, 32'h0);
    @(negedge clk); rdNow("R4 two edges", 8'h50, 32'hDEAD_BEEF);
    pinIn = '0; waitCyc(3);

    // R5 level mode: pin0 active high, pin1 active low
    wr(8'h3C, 32'h1);
    wr(8'h30, 32'h3);
    rd("R5 low-active", 8'h44, 32'h2);
    chk("R10 irq level", {31'b0, irqOut}, 32'h1);
    pinIn = 32'h3; waitCyc(2);
    rd("R5 high-active", 8'h44, 32'h1);
    wr(8'h4C, 32'h3);
    rd("R5 ack ignored", 8'h44, 32'h1);
    pinIn = '0; waitCyc(2);
    wr(8'h34, 32'h2);
    rd("R10 masked", 8'h40, 32'h0);
    chk("R10 irq masked", {31'b0, irqOut}, 32'h0);
    rd("R10 raw unmasked", 8'h44, 32'h2);
    wr(8'h30, 32'h0);
    rd("R9 level disabled", 8'h44, 32'h0);
    wr(8'h34, 32'h0);

    // R6 edge mode: pin4 rising, pin5 falling
    wr(8'h38, 32'h30);
    wr(8'h3C, 32'h10);
    wr(8'h30, 32'h30);
    waitCyc(2);
    rd("R6 quiet", 8'h44, 32'h0);
    @(negedge clk); pinIn = 32'h30;
    @(negedge clk);
    @(negedge clk); rdNow("R6 before capture", 8'h44, 32'h0);
    @(negedge clk); rdNow("R6 rising captured", 8'h44, 32'h10);
    pinIn = '0; waitCyc(3);
    rd("R6 hold and falling", 8'h44, 32'h30);
    rd("R10 masked edge", 8'h40, 32'h30);

    // R7 acknowledge
    wr(8'h4C, 32'h10);
    rd("R7 clear one", 8'h44, 32'h20);
    wr(8'h4C, 32'h0);
    rd("R7 zero no effect", 8'h44, 32'h20);
    wr(8'h4C, 32'h20);
    rd("R7 clear other", 8'h44, 32'h0);
    chk("R10 irq idle", {31'b0, irqOut}, 32'h0);

    // R8 edge captured in the acknowledge cycle
    @(negedge clk); pinIn = 32'h10;
    @(negedge clk);
    @(negedge clk);
    busAddr = 8'h4C; busWdata = 32'h10; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
    rdNow("R8 edge wins", 8'h44, 32'h10);
    wr(8'h4C, 32'h10);
    rd("R8 later clear", 8'h44, 32'h0);

    // R9 disabled edges are not captured
    wr(8'h30, 32'h0);
    pinIn = 32'h00; waitCyc(3);
    pinIn = 32'h30; waitCyc(3);
    pinIn = 32'h00; waitCyc(3);
    rd("R9 disabled raw", 8'h44, 32'h0);
    wr(8'h30, 32'h30);
    rd("R9 no stale capture", 8'h44, 32'h0);
    chk("R9 irq", {31'b0, irqOut}, 32'h0);

    finishRun();
  end

endmodule